// File: doc/BRIEF.md
# Byte-Wide Flash Command Controller

This block decodes the command protocol of a byte-wide NOR-style flash device and sequences its internal write engine. The nonvolatile array is modelled by on-chip RAM. The controller sits behind a clocked wrapper that samples the chip-enable, write-enable, output-enable, address and data inputs. A bus write is taken on the clock edge at which write-enable is seen rising while chip-enable is low. A read returns either array contents or the status byte, depending on the current read mode.

Program and erase run as timed background operations, and the ready output shows whether the engine is busy. An erase can be suspended so that the host can read other blocks or program another block. That program can in turn be suspended so that the host can read. Each resume continues the innermost suspended operation. A sleep input models deep power-down. It aborts all work and returns the device to array reads, and the stored contents are kept.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset, ready is 1, the read mode is array and the status byte is 80h.
- R2: Command FFh selects array reads and 70h selects status reads. Once a program or erase command sequence has been accepted, reads return status until FFh is written.
- R3: 40h followed by a write of a byte D at address A programs A. After completion, the stored value is the old value AND D, and ready stays low while the program runs.
- R4: 20h followed by D0h erases the block holding the address given on the D0h write, leaving every byte of that block at FFh. Block index = address bits above BLK_OFF_W.
- R5: If the second write after 20h is not D0h, status bits 5 and 4 are set. Both stay set until 50h is written, which clears them.
- R6: Status byte layout: bit7 = engine ready, bit6 = erase suspended, bit5 = erase error, bit4 = program error, bit2 = program suspended; all other bits are 0.
- R7: B0h written while an operation runs suspends it: ready goes to 1 and the matching suspend bit sets. B0h is ignored while the engine is idle.
- R8: D0h written while suspended resumes the operation. The suspend bit and bit7 clear, ready goes to 0, and the operation then completes.
- R9: While an erase is suspended, only FFh, 70h, 40h and D0h are accepted; other codes such as 50h have no effect. A program aimed at the suspended block is not performed and sets bit4.
- R10: While a program is suspended, only FFh, 70h and D0h are accepted; 40h, 50h and B0h have no effect.
- R11: With an erase suspended and a program suspended inside it, D0h resumes the program and leaves the erase suspended; a second D0h resumes the erase.
- R12: While the engine is busy, only 70h and B0h are accepted; FFh is ignored.
- R13: While sleep is low, operations and suspends are abandoned, errors clear, ready is 1 and reads return 00h. On exit, the read mode is array and the memory contents are kept.
- R14: Read data appears on dout one clock after chip-enable and output-enable are both sampled low; otherwise dout is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_n | input | 1 | Deep power-down when low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a rising edge takes the write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command or program data |
| dout | output | 8 | Read data or status |
| ready | output | 1 | 1 when the engine is idle or suspended |

## Verification
The bench builds the block with ADDR_W=8, BLK_OFF_W=4 and PROG_CYC=10. This gives sixteen 16-byte blocks, so erasing every block and checking whole blocks takes only a few hundred cycles. An erase lasts 16 cycles and a program lasts 11, which leaves enough time to land a suspend command in the middle of either one. With these sizes the bench can reach nested suspension, same-block program rejection and power-down during an erase. Random programs across the whole array are checked against a bench model of the AND rule.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int BLK_OFF_W = 8,
  parameter int PROG_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BLK_W = ADDR_W - BLK_OFF_W;
  localparam int CNT_W = $clog2(PROG_CYC + 1);
  localparam logic [7:0] C_ARRAY = 8'hFF, C_STAT = 8'h70, C_CLR = 8'h50,
                         C_ERASE = 8'h20, C_PROG = 8'h40, C_SUSP = 8'hB0, C_GO = 8'hD0;

  typedef enum logic [1:0] {P_NONE, P_ERASE, P_PROG} pend_t;

  logic [7:0] mem [DEPTH];
  logic we_q, stat_mode;
  pend_t pend;
  logic er_act, er_sus, pg_act, pg_sus, err_er, err_pg;
  logic [BLK_W-1:0] er_blk;
  logic [BLK_OFF_W-1:0] er_ptr;
  logic [ADDR_W-1:0] pg_addr;
  logic [7:0] pg_data;
  logic [CNT_W-1:0] pg_cnt;

  logic wr, pg_run, er_run, busy, acc, pg_done, er_done;
  logic [7:0] status;
  logic [BLK_W-1:0] a_blk;

  assign wr      = sleep_n & ~ce_n & ~we_q & we_n;
  assign pg_run  = pg_act & ~pg_sus;
  assign er_run  = er_act & ~er_sus & ~pg_act;
  assign busy    = pg_run | er_run;
  assign pg_done = pg_run && pg_cnt == '0;
  assign er_done = er_run && (&er_ptr);
  assign ready   = ~busy;
  assign status  = {~busy, er_sus, err_er, err_pg, 1'b0, pg_sus, 2'b00};
  assign a_blk   = addr[ADDR_W-1 -: BLK_W];

  always_comb begin
    if (busy)
      acc = din == C_STAT || din == C_SUSP;
    else if (pg_sus)
      acc = din == C_ARRAY || din == C_STAT || din == C_GO;
    else if (er_sus)
      acc = din == C_ARRAY || din == C_STAT || din == C_GO || din == C_PROG;
    else
      acc = din == C_ARRAY || din == C_STAT || din == C_CLR ||
            din == C_ERASE || din == C_PROG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !sleep_n) begin
      we_q <= 1'b1; stat_mode <= 1'b0; pend <= P_NONE;
      er_act <= 1'b0; er_sus <= 1'b0; pg_act <= 1'b0; pg_sus <= 1'b0;
      err_er <= 1'b0; err_pg <= 1'b0;
      er_blk <= '0; er_ptr <= '0; pg_addr <= '0; pg_data <= '0; pg_cnt <= '0;
    end else begin
      we_q <= we_n;
      if (pg_run) begin
        if (pg_done) pg_act <= 1'b0;
        else pg_cnt <= pg_cnt - 1'b1;
      end
      if (er_run) begin
        er_ptr <= er_ptr + 1'b1;
        if (er_done) er_act <= 1'b0;
      end
      if (wr) begin
        if (pend == P_ERASE) begin
          pend <= P_NONE;
          stat_mode <= 1'b1;
          if (din == C_GO) begin
            er_act <= 1'b1; er_blk <= a_blk; er_ptr <= '0;
          end else begin
            err_er <= 1'b1; err_pg <= 1'b1;
          end
        end else if (pend == P_PROG) begin
          pend <= P_NONE;
          stat_mode <= 1'b1;
          if (er_sus && a_blk == er_blk) err_pg <= 1'b1;
          else begin
            pg_act <= 1'b1; pg_addr <= addr; pg_data <= din; pg_cnt <= CNT_W'(PROG_CYC);
          end
        end else if (acc) begin
          case (din)
            C_ARRAY: stat_mode <= 1'b0;
            C_STAT:  stat_mode <= 1'b1;
            C_CLR:   begin err_er <= 1'b0; err_pg <= 1'b0; end
            C_ERASE: pend <= P_ERASE;
            C_PROG:  pend <= P_PROG;
            C_SUSP: begin
              stat_mode <= 1'b1;
              if (pg_run && !pg_done) pg_sus <= 1'b1;
              else if (er_run && !er_done) er_sus <= 1'b1;
            end
            C_GO: begin
              stat_mode <= 1'b1;
              if (pg_sus) pg_sus <= 1'b0;
              else er_sus <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && sleep_n) begin
      if (pg_done) mem[pg_addr] <= mem[pg_addr] & pg_data;
      else if (er_run) mem[{er_blk, er_ptr}] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 8'h00;
    else if (!sleep_n || ce_n || oe_n) dout <= 8'h00;
    else dout <= stat_mode ? status : mem[addr];
  end
endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_n,
  input logic       wr,
  input logic [7:0] din,
  input logic       ready,
  input logic       er_sus,
  input logic       pg_sus,
  input logic       pg_act,
  input logic       err_er
);
  assert_prog_susp_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pg_sus |-> ready);

  assert_erase_susp_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (er_sus && !pg_act) |-> ready);

  assert_resume_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && din == 8'hD0 && pg_sus) |=> !ready);

  assert_nested_keep_erase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && din == 8'hD0 && pg_sus && er_sus) |=> er_sus);

  assert_error_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && err_er && !(wr && din == 8'h50)) |=> err_er);

  assert_sleep_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> ready);
endmodule

bind nor_cmd_ctrl nor_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .wr(wr), .din(din),
  .ready(ready), .er_sus(er_sus), .pg_sus(pg_sus), .pg_act(pg_act), .err_er(err_er)
);

// File: tb/tb_nor_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_nor_cmd_ctrl;
  localparam int AW = 8, OW = 4, PC = 10;
  localparam int NB = 1 << (AW - OW);

  logic clk = 0, rst_n = 0, sleep_n = 1, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic ready;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [1<<AW];

  nor_cmd_ctrl #(.ADDR_W(AW), .BLK_OFF_W(OW), .PROG_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .ready(ready));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] sbyte(bit rdy, bit es, bit ee, bit ep, bit ps);
    return {rdy, es, ee, ep, 1'b0, ps, 2'b00};
  endfunction

  function automatic logic [AW-1:0] baddr(int b, int off);
    return AW'((b << OW) | off);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwrite(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; din = d;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic bread(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk); d = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
  endtask

  task automatic erase_blk(int b);
    bwrite(baddr(b, 0), 8'h20);
    bwrite(baddr(b, 3), 8'hD0);
  endtask

  task automatic model_erase(int b);
    for (int o = 0; o < (1 << OW); o++) model[baddr(b, o)] = 8'hFF;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [AW-1:0] a;
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", {7'd0, ready}, 8'h01);
    check("R14 dout idle", dout, 8'h00);
    bwrite(0, 8'h70); bread(0, r);
    check("R1 R6 status after reset", r, sbyte(1,0,0,0,0));
    bwrite(0, 8'hB0); bread(0, r);
    check("R7 suspend ignored when idle", r, sbyte(1,0,0,0,0));

    for (int b = 0; b < NB; b++) begin
      erase_blk(b);
      if (b == 0) check("R4 busy during erase", {7'd0, ready}, 8'h00);
      wait_ready();
      model_erase(b);
    end
    bread(0, r);
    check("R2 status mode after erase", r, sbyte(1,0,0,0,0));
    bwrite(0, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      a = AW'($urandom);
      bread(a, r);
      check("R4 erased byte", r, 8'hFF);
    end

    for (int i = 0; i < 40; i++) begin
      a = AW'($urandom); d = 8'($urandom);
      bwrite(a, 8'h40); bwrite(a, d);
      if (i == 0) check("R3 busy during program", {7'd0, ready}, 8'h00);
      wait_ready();
      model[a] = model[a] & d;
      if (i % 8 == 0) begin bread(a, r); check("R2 status after program", r, sbyte(1,0,0,0,0)); end
      bwrite(0, 8'hFF);
      bread(a, r); check("R3 programmed byte", r, model[a]);
      a = AW'($urandom); bread(a, r); check("R3 random read", r, model[a]);
    end

    a = baddr(2, 5);
    erase_blk(2); wait_ready(); model_erase(2);
    bwrite(a, 8'h40); bwrite(a, 8'hA5); wait_ready();
    bwrite(a, 8'h40); bwrite(a, 8'h3C); wait_ready();
    model[a] = 8'h24;
    bwrite(0, 8'hFF); bread(a, r);
    check("R3 AND of two programs", r, 8'h24);

    bwrite(0, 8'h20); bwrite(0, 8'h40); bread(0, r);
    check("R5 bad erase confirm", r, sbyte(1,0,1,1,0));
    bwrite(0, 8'hFF); bwrite(0, 8'h70); bread(0, r);
    check("R5 error sticky", r, sbyte(1,0,1,1,0));
    bwrite(0, 8'h50); bread(0, r);
    check("R5 clear status", r, sbyte(1,0,0,0,0));

    a = baddr(4, 1);
    bwrite(a, 8'h40); bwrite(a, 8'h0F);
    bwrite(0, 8'hFF); bread(a, r);
    check("R12 FFh ignored while busy", r, sbyte(0,0,0,0,0));
    wait_ready(); model[a] = model[a] & 8'h0F;

    bwrite(0, 8'h20); bwrite(0, 8'h00);
    erase_blk(3);
    bwrite(0, 8'hB0);
    check("R7 ready after erase suspend", {7'd0, ready}, 8'h01);
    bread(0, r); check("R7 erase suspended status", r, sbyte(1,1,1,1,0));
    bwrite(0, 8'h50); bread(0, r);
    check("R9 clear ignored in erase suspend", r, sbyte(1,1,1,1,0));
    bwrite(0, 8'hFF); bread(baddr(5, 2), r);
    check("R9 array read in erase suspend", r, model[baddr(5, 2)]);
    a = baddr(5, 2);
    bwrite(a, 8'h40); bwrite(a, 8'h81);
    bread(0, r); check("R9 program in erase suspend", r, sbyte(0,1,1,1,0));
    bwrite(0, 8'hB0);
    bread(0, r); check("R10 program suspended status", r, sbyte(1,1,1,1,1));
    bwrite(baddr(6, 7), 8'h40); bwrite(baddr(6, 7), 8'h00);
    bwrite(0, 8'hB0); bwrite(0, 8'h50);
    bread(0, r); check("R10 commands ignored", r, sbyte(1,1,1,1,1));
    bwrite(0, 8'hD0);
    check("R8 ready low on resume", {7'd0, ready}, 8'h00);
    bread(0, r); check("R11 program resumed first", r, sbyte(0,1,1,1,0));
    wait_ready(); model[a] = model[a] & 8'h81;
    bread(0, r); check("R11 erase still suspended", r, sbyte(1,1,1,1,0));
    bwrite(0, 8'hFF); bread(a, r);
    check("R11 nested program data", r, model[a]);
    bwrite(0, 8'hD0); bread(0, r);
    check("R8 erase resumed", r, sbyte(0,0,1,1,0));
    wait_ready(); model_erase(3);
    bwrite(0, 8'h50); bwrite(0, 8'hFF);
    for (int o = 0; o < (1 << OW); o++) begin
      bread(baddr(3, o), r); check("R4 R8 block erased after resume", r, 8'hFF);
    end
    bread(baddr(6, 7), r);
    check("R10 ignored program left byte", r, model[baddr(6, 7)]);

    erase_blk(7); bwrite(0, 8'hB0);
    bwrite(baddr(7, 2), 8'h40); bwrite(baddr(7, 2), 8'h00);
    bread(0, r); check("R9 same block program rejected", r, sbyte(1,1,0,1,0));
    bwrite(0, 8'hD0); wait_ready(); model_erase(7);
    bwrite(0, 8'h50); bwrite(0, 8'hFF);
    bread(baddr(7, 2), r); check("R9 rejected byte erased", r, 8'hFF);

    erase_blk(9);
    @(negedge clk); sleep_n = 0;
    repeat (3) @(negedge clk);
    check("R13 ready in sleep", {7'd0, ready}, 8'h01);
    bread(baddr(5, 2), r); check("R13 dout in sleep", r, 8'h00);
    @(negedge clk); sleep_n = 1;
    bread(baddr(5, 2), r); check("R13 array mode kept data", r, model[baddr(5, 2)]);
    bwrite(0, 8'h70); bread(0, r); check("R13 status after sleep", r, sbyte(1,0,0,0,0));
    erase_blk(9); wait_ready(); model_erase(9);

    for (int i = 0; i < 4; i++) begin
      int b;
      b = int'($urandom % NB);
      erase_blk(b); wait_ready(); model_erase(b);
      bwrite(0, 8'hFF);
      for (int k = 0; k < 4; k++) begin
        a = AW'($urandom); bread(a, r); check("R4 random erase", r, model[a]);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule